// File: doc/BRIEF.md
# Serial Multiply/Divide Unit

This block computes an unsigned 8x8 product or an unsigned 16/8 quotient and remainder. It works one bit per step pulse. Both operations share three registers: a 16-bit product/remainder register, a 16-bit quotient/multiplier register and a 24-bit shift register that carries the moving operand. Each operation has its own step down-counter and its own one-step "last" flag. The flag tells the surrounding logic when the final iteration has happened.

Software loads the multiplicand into a holding register. Writing the multiplier then starts a multiply, which finishes after 8 steps. In the same way, the dividend goes into a holding register and writing the divisor starts a divide, which finishes after 16 steps. The step pulse comes from an external clock divider. Steps may arrive on consecutive cycles or with gaps between them. Between steps the result registers hold their values.

Top module: `mdu_serial`

## Requirements
- R1: After reset, `prod_rem`, `quot`, `mul_last`, `div_last` and `busy` are all zero.
- R2: A write on `mplier_wr` starts a multiply. It loads the multiplicand into the shift register, loads the multiplier into the quotient register, clears `prod_rem` and sets the multiply counter to 8. After 8 steps `prod_rem` equals multiplicand times multiplier.
- R3: On each multiply step, the shift register is added to `prod_rem` when bit 0 of the quotient register is 1. The quotient register then shifts right by one and the shift register shifts left by one. After k steps, `prod_rem` equals multiplicand times (multiplier mod 2^k).
- R4: A write on `dvs_wr` starts a divide. It places the divisor in bits 23:16 of the shift register, loads the dividend into `prod_rem`, clears `quot` and sets the divide counter to 16. After 16 steps `quot` is the quotient and `prod_rem` is the remainder.
- R5: On each divide step, `quot` shifts left and the shift register shifts right. If `prod_rem` is greater than or equal to the shift register, the shift value is then subtracted and bit 0 of `quot` is set. With a zero divisor, this gives `quot` = 0xFFFF and `prod_rem` = the dividend.
- R6: A step that takes an operation's counter from 1 to 0 sets that operation's last flag (`mul_last` or `div_last`). The flag of the other operation is not set.
- R7: A step that finds an operation's counter already at zero clears that operation's last flag.
- R8: `busy` is high exactly while either counter is nonzero.
- R9: A step while both counters are zero leaves `prod_rem` and `quot` unchanged.
- R10: Starting either operation clears the other operation's counter. Any operation in progress is abandoned.
- R11: When a start write and a step arrive in the same cycle, the start takes effect and the step is dropped. When both start writes arrive together, the multiply wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcand_wr | input | 1 | Write strobe for the multiplicand holding register |
| mcand_in | input | 8 | Multiplicand |
| mplier_wr | input | 1 | Write strobe for the multiplier; starts a multiply |
| mplier_in | input | 8 | Multiplier |
| dvd_wr | input | 1 | Write strobe for the dividend holding register |
| dvd_in | input | 16 | Dividend |
| dvs_wr | input | 1 | Write strobe for the divisor; starts a divide |
| dvs_in | input | 8 | Divisor |
| step | input | 1 | Iteration pulse |
| prod_rem | output | 16 | Product or remainder |
| quot | output | 16 | Quotient, or the multiplier while it is being consumed |
| mul_last | output | 1 | Final multiply step occurred on the last step pulse |
| div_last | output | 1 | Final divide step occurred on the last step pulse |
| busy | output | 1 | An operation is in progress |

## Verification
The multiply is tried with zero, full-scale and sparse-bit operands. At every step the partial product is compared against multiplicand times the low bits of the multiplier consumed so far, which separates a wrong add condition from a wrong shift direction. The divide is tried with exact, remainder-producing, divisor-one, divisor-larger-than-dividend and zero-divisor operands. The zero divisor and full-scale cases expose an off-by-one in the shift register width or the comparison. Step pulses with gaps, steps while idle, a start colliding with a step, and a multiply started during a divide separate the counters, the last-flag set and clear rules, and the start priority.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned MDU_OPW = 8;
  typedef enum logic [1:0] {
    MDU_HOLD  = 2'd0,
    MDU_MSTRT = 2'd1,
    MDU_DSTRT = 2'd2,
    MDU_ITER  = 2'd3
  } mdu_act_e;
endpackage

// File: rtl/mdu_mul_iter.sv
module mdu_mul_iter #(
  parameter int unsigned OPW = 8,
  localparam int unsigned RW = 2 * OPW,
  localparam int unsigned SW = 3 * OPW
) (
  input  logic          en,
  input  logic [RW-1:0] q_i,
  input  logic [RW-1:0] r_i,
  input  logic [SW-1:0] s_i,
  output logic [RW-1:0] q_o,
  output logic [RW-1:0] r_o,
  output logic [SW-1:0] s_o
);
  always_comb begin
    q_o = q_i;
    r_o = r_i;
    s_o = s_i;
    if (en) begin
      if (q_i[0]) r_o = r_i + s_i[RW-1:0];
      q_o = q_i >> 1;
      s_o = s_i << 1;
    end
  end
endmodule

// File: rtl/mdu_div_iter.sv
module mdu_div_iter #(
  parameter int unsigned OPW = 8,
  localparam int unsigned RW = 2 * OPW,
  localparam int unsigned SW = 3 * OPW
) (
  input  logic          en,
  input  logic [RW-1:0] q_i,
  input  logic [RW-1:0] r_i,
  input  logic [SW-1:0] s_i,
  output logic [RW-1:0] q_o,
  output logic [RW-1:0] r_o,
  output logic [SW-1:0] s_o
);
  logic [SW-1:0] s_sh;
  logic [SW-1:0] r_ext;

  always_comb begin
    s_sh  = s_i >> 1;
    r_ext = {{(SW-RW){1'b0}}, r_i};
    q_o   = q_i;
    r_o   = r_i;
    s_o   = s_i;
    if (en) begin
      q_o = q_i << 1;
      s_o = s_sh;
      if (r_ext >= s_sh) begin
        r_o    = r_i - s_sh[RW-1:0];
        q_o[0] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdu_step_ctr.sv
module mdu_step_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_n;
  logic          last_n;
  logic          upd;

  always_comb begin
    cnt_n  = cnt;
    last_n = last;
    upd    = load | step;
    if (load) begin
      cnt_n = load_val;
    end else if (step) begin
      if (cnt != '0) begin
        cnt_n = cnt - 1'b1;
        if (cnt == CW'(1)) last_n = 1'b1;
      end else begin
        last_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      last <= 1'b0;
    end else if (upd) begin
      cnt  <= cnt_n;
      last <= last_n;
    end
  end

  // R6
  last_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt == CW'(1)) |=> last);

  // R7
  last_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt == '0) |=> !last);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(cnt) && $stable(last)));
endmodule

// File: rtl/mdu_serial.sv
module mdu_serial
  import mdu_pkg::*;
#(
  parameter int unsigned OPW = MDU_OPW,
  localparam int unsigned RW  = 2 * OPW,
  localparam int unsigned SW  = 3 * OPW,
  localparam int unsigned MCW = $clog2(OPW + 1),
  localparam int unsigned DCW = $clog2(RW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mcand_wr,
  input  logic [OPW-1:0] mcand_in,
  input  logic           mplier_wr,
  input  logic [OPW-1:0] mplier_in,
  input  logic           dvd_wr,
  input  logic [RW-1:0]  dvd_in,
  input  logic           dvs_wr,
  input  logic [OPW-1:0] dvs_in,
  input  logic           step,
  output logic [RW-1:0]  prod_rem,
  output logic [RW-1:0]  quot,
  output logic           mul_last,
  output logic           div_last,
  output logic           busy
);
  logic [OPW-1:0] mcand_q, mcand_eff;
  logic [RW-1:0]  dvd_q, dvd_eff;
  logic [RW-1:0]  q_r, r_r, q_n, r_n;
  logic [SW-1:0]  s_r, s_n;
  logic [RW-1:0]  q_m, r_m, q_d, r_d;
  logic [SW-1:0]  s_m, s_d;
  logic [MCW-1:0] mcnt;
  logic [DCW-1:0] dcnt;
  logic           mul_go, div_go, ctr_load;
  mdu_act_e       act;

  assign mul_go   = mplier_wr;
  assign div_go   = dvs_wr & ~mplier_wr;
  assign ctr_load = mul_go | div_go;

  always_comb begin
    mcand_eff = mcand_wr ? mcand_in : mcand_q;
    dvd_eff   = dvd_wr ? dvd_in : dvd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (mcand_wr) begin
      mcand_q <= mcand_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
    end else if (dvd_wr) begin
      dvd_q <= dvd_in;
    end
  end

  mdu_mul_iter #(.OPW(OPW)) u_mul (
    .en  (mcnt != '0),
    .q_i (q_r), .r_i (r_r), .s_i (s_r),
    .q_o (q_m), .r_o (r_m), .s_o (s_m)
  );

  mdu_div_iter #(.OPW(OPW)) u_div (
    .en  (dcnt != '0),
    .q_i (q_m), .r_i (r_m), .s_i (s_m),
    .q_o (q_d), .r_o (r_d), .s_o (s_d)
  );

  always_comb begin
    if (mul_go)      act = MDU_MSTRT;
    else if (div_go) act = MDU_DSTRT;
    else if (step)   act = MDU_ITER;
    else             act = MDU_HOLD;
  end

  always_comb begin
    q_n = q_r;
    r_n = r_r;
    s_n = s_r;
    unique case (act)
      MDU_MSTRT: begin
        q_n = {{(RW-OPW){1'b0}}, mplier_in};
        r_n = '0;
        s_n = {{(SW-OPW){1'b0}}, mcand_eff};
      end
      MDU_DSTRT: begin
        q_n = '0;
        r_n = dvd_eff;
        s_n = {dvs_in, {RW{1'b0}}};
      end
      MDU_ITER: begin
        q_n = q_d;
        r_n = r_d;
        s_n = s_d;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
      r_r <= '0;
      s_r <= '0;
    end else if (act != MDU_HOLD) begin
      q_r <= q_n;
      r_r <= r_n;
      s_r <= s_n;
    end
  end

  mdu_step_ctr #(.CW(MCW)) u_mctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (mul_go ? MCW'(OPW) : '0),
    .step     (step),
    .cnt      (mcnt),
    .last     (mul_last)
  );

  mdu_step_ctr #(.CW(DCW)) u_dctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (div_go ? DCW'(RW) : '0),
    .step     (step),
    .cnt      (dcnt),
    .last     (div_last)
  );

  assign busy     = (mcnt != '0) | (dcnt != '0);
  assign prod_rem = r_r;
  assign quot     = q_r;

  // R2
  mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mplier_wr |=> (busy && prod_rem == '0));

  // R4
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_wr && !mplier_wr) |=> (busy && quot == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !busy && !mplier_wr && !dvs_wr) |=> ($stable(prod_rem) && $stable(quot)));

  // R10
  excl_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((mcnt != '0) && (dcnt != '0)));

  // R6
  one_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_last) |-> !$rose(div_last));
endmodule

// File: tb/tb_mdu_serial.sv
module tb_mdu_serial;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mcand_wr = 1'b0, mplier_wr = 1'b0, dvd_wr = 1'b0, dvs_wr = 1'b0, step = 1'b0;
  logic [7:0]  mcand_in = '0, mplier_in = '0, dvs_in = '0;
  logic [15:0] dvd_in = '0;
  logic [15:0] prod_rem, quot;
  logic        mul_last, div_last, busy;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_serial dut (
    .clk(clk), .rst_n(rst_n),
    .mcand_wr(mcand_wr), .mcand_in(mcand_in),
    .mplier_wr(mplier_wr), .mplier_in(mplier_in),
    .dvd_wr(dvd_wr), .dvd_in(dvd_in),
    .dvs_wr(dvs_wr), .dvs_in(dvs_in),
    .step(step),
    .prod_rem(prod_rem), .quot(quot),
    .mul_last(mul_last), .div_last(div_last), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic start_mul(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); mcand_wr = 1'b1; mcand_in = a;
    @(negedge clk); mcand_wr = 1'b0; mplier_wr = 1'b1; mplier_in = b;
    @(negedge clk); mplier_wr = 1'b0;
  endtask

  task automatic start_div(input logic [15:0] n, input logic [7:0] d);
    @(negedge clk); dvd_wr = 1'b1; dvd_in = n;
    @(negedge clk); dvd_wr = 1'b0; dvs_wr = 1'b1; dvs_in = d;
    @(negedge clk); dvs_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 prod_rem", prod_rem, 0);
    chk("R1 quot", quot, 0);
    chk("R1 flags/busy", {mul_last, div_last, busy}, 0);
  endtask

  task automatic t_mul(input logic [7:0] a, input logic [7:0] b, input bit gaps);
    start_mul(a, b);
    chk("R2 cleared", prod_rem, 0);
    chk("R8 busy on start", busy, 1);
    for (int k = 1; k <= 8; k++) begin
      pulse_step();
      if (gaps) repeat (2) @(negedge clk);
      chk("R3 partial", prod_rem, 32'(a) * (32'(b) & ((32'd1 << k) - 1)));
      if (k < 8) chk("R6 not yet", {mul_last, busy}, 2'b01);
    end
    chk("R2 product", prod_rem, 32'(a) * 32'(b));
    chk("R6 mul_last", {mul_last, div_last}, 2'b10);
    chk("R8 idle", busy, 0);
    pulse_step();
    chk("R7 mul_last cleared", mul_last, 0);
    chk("R9 held", prod_rem, 32'(a) * 32'(b));
  endtask

  task automatic t_div(input logic [15:0] n, input logic [7:0] d);
    logic [15:0] eq, er;
    eq = (d == 0) ? 16'hFFFF : n / 16'(d);
    er = (d == 0) ? n : n % 16'(d);
    start_div(n, d);
    chk("R4 loaded", {prod_rem, quot}, {n, 16'h0});
    for (int k = 1; k <= 16; k++) begin
      pulse_step();
      if (k < 16) chk("R8 busy", {div_last, busy}, 2'b01);
    end
    chk(d == 0 ? "R5 quot div0" : "R4 quot", quot, eq);
    chk(d == 0 ? "R5 rem div0" : "R4 rem", prod_rem, er);
    chk("R6 div_last", {mul_last, div_last, busy}, 3'b010);
    pulse_step();
    chk("R7 div_last cleared", div_last, 0);
    chk("R9 held", {prod_rem, quot}, {er, eq});
  endtask

  task automatic t_cancel();
    start_div(16'd1000, 8'd7);
    repeat (4) pulse_step();
    start_mul(8'd13, 8'd11);
    repeat (8) pulse_step();
    chk("R10 busy after cancel", busy, 0);
    chk("R10 product", prod_rem, 143);
    chk("R10 div_last", div_last, 0);
  endtask

  task automatic t_priority();
    @(negedge clk); mcand_wr = 1'b1; mcand_in = 8'd200;
    @(negedge clk); mcand_wr = 1'b0;
    mplier_wr = 1'b1; mplier_in = 8'd3; dvs_wr = 1'b1; dvs_in = 8'd5; step = 1'b1;
    @(negedge clk); mplier_wr = 1'b0; dvs_wr = 1'b0; step = 1'b0;
    chk("R11 step dropped", prod_rem, 0);
    repeat (7) pulse_step();
    chk("R11 still busy", busy, 1);
    pulse_step();
    chk("R11 mul wins", {busy, mul_last, div_last}, 3'b010);
    chk("R11 product", prod_rem, 600);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    pulse_step();
    chk("R9 idle step", {prod_rem, quot}, 0);
    t_mul(8'd0, 8'd0, 1'b0);
    t_mul(8'd255, 8'd255, 1'b0);
    t_mul(8'd37, 8'b1010_0101, 1'b1);
    t_div(16'd1000, 8'd7);
    t_div(16'hFFFF, 8'd1);
    t_div(16'd255, 8'd255);
    t_div(16'd9, 8'd200);
    t_div(16'hABCD, 8'd0);
    t_cancel();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule